// File: doc/BRIEF.md
# Write-Once Flash Timing Clock Divider

This block holds one 8-bit configuration register and the divider it controls. Together they turn the oscillator clock into a slow timing tick that paces program and erase pulses in an embedded flash controller. Software picks a prescaler setting and a 6-bit divide value so that the tick rate lands between 150 kHz and 200 kHz. The highest overall ratio is 512. The configuration can be written only once after each reset. The top bit of the register is a read-only flag that shows whether that write has happened.

A small state machine drives the block. It has two states. `ST_UNCFG` is the reset state: the configuration is open, the divider is held and `ready` is low. `ST_RUN` is entered through the transition `CFG_WRITE`, which is any bus write. In `ST_RUN` the configuration is frozen, the divider runs and `ready` is high. The only way to leave `ST_RUN` is `HW_RESET`, which is the asynchronous reset. Write attempts made in `ST_RUN` follow the self-loop `WRITE_IGNORED`. The tick is a one-cycle enable pulse in the oscillator clock domain.

Top module: `flash_tdiv`

## Requirements
- R1: After reset, `bus_rdata` reads 0x00, and both `ready` and `tick` are low.
- R2: A clock edge with `bus_en` and `bus_we` both high counts as a write. The first write after reset stores `bus_wdata[6:0]` and sets bit 7 of `bus_rdata` (the loaded flag) to 1. This happens even when the written data is 0x00.
- R3: Once the loaded flag is set, later writes leave bits 6..0 unchanged.
- R4: Bit 7 cannot be written. The value of `bus_wdata[7]` has no effect, and bit 7 shows only the loaded flag.
- R5: When bit 6 is 0, the prescaler is bypassed. The overall division ratio is then the bits 5..0 value plus 1, which gives 1 to 64.
- R6: When bit 6 is 1, the oscillator is divided by 8 ahead of the main divider. The ratio is then 8 × (bits 5..0 + 1), up to 512 for 0x7F.
- R7: Count cycles from the write edge, with the cycle just after that edge as cycle 0. The first `tick` then falls in cycle ratio−1. Each later `tick` follows exactly ratio cycles after the one before, and every `tick` lasts one cycle.
- R8: `tick` stays low while the loaded flag is 0. `ready` is 0 before the first write and 1 from cycle 0 after it.
- R9: An access with `bus_en` high and `bus_we` low is a read. A read neither sets the flag nor changes the configuration.
- R10: A reset clears the register and reopens it, so the next write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: {loaded, prescale enable, divide value} |
| tick | output | 1 | One-cycle timing enable |
| ready | output | 1 | Divider configured and running |

## Verification
The register, the loaded flag and `ready` change on the write edge itself. The bench drives each access half a cycle before the edge and samples at the next falling edge, which is cycle 0. The first tick is due in cycle ratio−1 and each later one ratio cycles after it. The bench therefore compares `tick` against that pattern at every falling edge across two full periods. This catches both an off-by-one in the count and a missing prescaler.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int REG_W = 8;
    localparam int DIV_W = 6;
    localparam int PRE_RATIO_DEF = 8;

    typedef enum logic {
        ST_UNCFG = 1'b0,
        ST_RUN   = 1'b1
    } fdiv_state_e;

    typedef struct packed {
        logic             pre_on;
        logic [DIV_W-1:0] div;
    } fdiv_cfg_t;
endpackage

// File: rtl/fdiv_cfg_reg.sv
module fdiv_cfg_reg
    import fdiv_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [REG_W-1:0]    wdata,
    output fdiv_cfg_t           cfg,
    output logic                loaded
);
    fdiv_state_e state_q, state_d;
    fdiv_cfg_t   cfg_q;

    // next-state: CFG_WRITE, WRITE_IGNORED, HW_RESET (async)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCFG: if (wr_stb) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_UNCFG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNCFG;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_UNCFG && wr_stb)
                cfg_q <= wdata[REG_W-2:0];
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_UNCFG: loaded = 1'b0;
            ST_RUN:   loaded = 1'b1;
            default:  loaded = 1'b0;
        endcase
        cfg = cfg_q;
    end

    p_loaded_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> loaded)
        else $error("loaded flag dropped");

    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> $stable(cfg))
        else $error("configuration changed after load");
endmodule

// File: rtl/fdiv_prescale.sv
module fdiv_prescale #(
    parameter int RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic enable,
    output logic step
);
    generate
        if (RATIO > 1) begin : g_div
            localparam int PW = $clog2(RATIO);
            localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
            logic [PW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              cnt_q <= '0;
                else if (!run)           cnt_q <= '0;
                else if (cnt_q == LAST)  cnt_q <= '0;
                else                     cnt_q <= cnt_q + 1'b1;
            end

            assign step = run && (!enable || cnt_q == LAST);

            p_step_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (enable && step) |=> !step)
                else $error("prescaled steps adjacent");
        end else begin : g_pass
            assign step = run;
        end
    endgenerate
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (step) begin
            if (cnt_q == limit)  cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && step && (cnt_q == limit);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit))
        else $error("divider count beyond limit");
endmodule

// File: rtl/flash_tdiv.sv
module flash_tdiv
    import fdiv_pkg::*;
#(
    parameter int PRE_RATIO = PRE_RATIO_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             tick,
    output logic             ready
);
    fdiv_cfg_t cfg;
    logic      loaded;
    logic      pre_step;

    fdiv_cfg_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (bus_en && bus_we),
        .wdata  (bus_wdata),
        .cfg    (cfg),
        .loaded (loaded)
    );

    fdiv_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (loaded),
        .enable (cfg.pre_on),
        .step   (pre_step)
    );

    fdiv_counter #(.W(DIV_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (loaded),
        .step  (pre_step),
        .limit (cfg.div),
        .tick  (tick)
    );

    assign bus_rdata = {loaded, cfg};
    assign ready     = loaded;

    p_quiet_unloaded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[REG_W-1] |-> !tick)
        else $error("tick while unconfigured");
endmodule

// File: tb/flash_tdiv_tb_top.sv
module flash_tdiv_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick;
    logic       ready;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_tdiv dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .ready(ready)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // returns at the falling edge of cycle 0 after the access edge
    task automatic access(input logic we, input logic [7:0] d);
        bus_en = 1'b1; bus_we = we; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic check_ticks(input string req, input int ratio);
        int errs = 0;
        int first = -1;
        for (int idx = 0; idx < 2 * ratio + 2; idx++) begin
            logic exp_t = ((idx + 1) % ratio) == 0;
            if (tick !== exp_t) errs++;
            if (tick === 1'b1 && first < 0) first = idx;
            @(negedge clk);
        end
        check({req, " first tick cycle"}, first, ratio - 1);
        check({req, " tick pattern errors"}, errs, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 ready", ready, 0);
        check("R1 tick", tick, 0);
    endtask

    task automatic t_read_no_load();
        do_reset();
        access(1'b0, 8'h45);
        check("R9 rdata after read", bus_rdata, 8'h00);
        check("R8 ready before write", ready, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                if (tick) seen++;
                @(negedge clk);
            end
            check("R8 no tick unloaded", seen, 0);
        end
    endtask

    task automatic t_write_zero();
        do_reset();
        access(1'b1, 8'h00);
        check("R2 zero write loads", bus_rdata, 8'h80);
        check("R8 ready after write", ready, 1);
        check_ticks("R5 ratio1", 1);
    endtask

    task automatic t_direct_div();
        do_reset();
        access(1'b1, 8'h85);
        check("R4 bit7 ignored", bus_rdata, 8'h85);
        check_ticks("R7 ratio6", 6);
        access(1'b1, 8'h4A);
        check("R3 second write ignored", bus_rdata, 8'h85);
    endtask

    task automatic t_prescaled();
        do_reset();
        access(1'b1, 8'h42);
        check("R2 stores cfg", bus_rdata, 8'hC2);
        check_ticks("R6 ratio24", 24);
    endtask

    task automatic t_max_ratio();
        do_reset();
        access(1'b1, 8'h7F);
        check("R6 max cfg", bus_rdata, 8'hFF);
        check_ticks("R6 ratio512", 512);
    endtask

    task automatic t_div64();
        do_reset();
        access(1'b1, 8'h3F);
        check_ticks("R5 ratio64", 64);
        access(1'b1, 8'h00);
        check("R3 overwrite blocked", bus_rdata, 8'hBF);
    endtask

    task automatic t_reset_reopens();
        do_reset();
        access(1'b1, 8'h03);
        do_reset();
        check("R10 cleared", bus_rdata, 8'h00);
        access(1'b1, 8'h01);
        check("R10 rewrite accepted", bus_rdata, 8'h81);
        check_ticks("R10 ratio2", 2);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_read_no_load();
        t_write_zero();
        t_direct_div();
        t_prescaled();
        t_max_ratio();
        t_div64();
        t_reset_reopens();
        finish_run();
    end
endmodule